// File: doc/BRIEF.md
# Successive-Approximation Error-Rate Calibrator

This block tunes a delay control word so that a sampling point lands where a chosen share of parity samples come out wrong. On each query strobe it XORs the sampled erroneous parity bit with the sampled correct parity bit, and it adds mismatches to a saturating counter over a window with a fixed number of queries. When a window closes, the count is compared with a programmed target, and the control word moves one bit closer to its final value by binary search, most significant bit first.

A larger code means more delay, and more delay means fewer errors. The search therefore keeps a trial bit when the window still showed at least the target number of errors, and drops that bit when the window showed fewer. The first window runs with an all-zero code. Each of the following windows trials one bit. After the least significant bit has been decided, the block raises its lock output and freezes the code. From then on it ignores queries until a recalibration request or a reset.

Top module: `sar_cal_ctrl`

## Requirements
- R1: A query counts as an error when `err_bit_i` differs from `ref_bit_i` in a cycle with `query_i` high. Mismatches in cycles with `query_i` low have no effect.
- R2: A window is 2^WIN_LOG2 accepted queries. `ctrl_o` and `locked_o` change only at the clock edge that accepts the last query of a window, or at a recalibration.
- R3: The per-window error counter is WIN_LOG2 bits wide and saturates at 2^WIN_LOG2-1, so a window in which every query is an error does not wrap to a small count.
- R4: After the asynchronous reset `rst_ni`, `ctrl_o` is zero and `locked_o` is low.
- R5: The first window runs with `ctrl_o` at zero. At its end, `ctrl_o` becomes the value with only the most significant bit set, whatever the count.
- R6: At the end of each later window, the bit under trial is cleared if the count is below `target_i` and kept otherwise. The next lower bit is then set as the new trial. Bits below the trial bit are always zero.
- R7: After CTRL_W+1 windows, `locked_o` rises. `ctrl_o` then holds the largest code whose window count reached the target, or zero if no code did.
- R8: While `locked_o` is high, queries are ignored, and `ctrl_o` and `locked_o` hold their values.
- R9: `recal_i` high at a clock edge restarts calibration. `ctrl_o` becomes zero, `locked_o` goes low and the window restarts empty. `recal_i` takes priority over a query in the same cycle.
- R10: The count and `target_i` are compared as unsigned numbers. A count equal to the target keeps the trial bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| recal_i | input | 1 | Synchronous restart of calibration |
| query_i | input | 1 | Query strobe, one sample pair per high cycle |
| err_bit_i | input | 1 | Sampled erroneous parity bit |
| ref_bit_i | input | 1 | Sampled correct parity bit |
| target_i | input | WIN_LOG2 | Target error count per window, unsigned |
| ctrl_o | output | CTRL_W | Delay control word |
| locked_o | output | 1 | Calibration finished, code frozen |

## Verification
The bench builds the block with CTRL_W=6 and WIN_LOG2=3, so a window is eight queries and a full calibration is 56 queries. At this size the bench can run several complete searches against delay-to-error plant curves it defines itself, and it can compute the expected final code by scanning all 64 codes. The three-bit counter reaches saturation when all eight queries in a window are errors, which exercises R3. The small window also makes it cheap to land a recalibration request in the middle of a window, on the same cycle as a query.

// File: rtl/sar_cal_pkg.sv
package sar_cal_pkg;

  typedef enum logic [1:0] {
    CAL_BASE  = 2'd0,
    CAL_TRIAL = 2'd1,
    CAL_LOCK  = 2'd2
  } cal_state_e;

  function automatic logic [15:0] sat_add1(input logic [15:0] val, input logic inc,
                                           input logic [15:0] max_val);
    if (!inc || val >= max_val) return (val >= max_val) ? max_val : val;
    return val + 16'd1;
  endfunction

endpackage

// File: rtl/err_window_acc.sv
module err_window_acc #(
  parameter int WIN_LOG2 = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                en_i,
  input  logic                err_bit_i,
  input  logic                ref_bit_i,
  output logic                done_o,
  output logic [WIN_LOG2-1:0] count_o,
  output logic [WIN_LOG2-1:0] cnt_q_o
);
  import sar_cal_pkg::*;

  localparam int CNT_W = WIN_LOG2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [WIN_LOG2-1:0] LAST_Q = {WIN_LOG2{1'b1}};

  logic [CNT_W-1:0]    cnt_q;
  logic [WIN_LOG2-1:0] qidx_q;
  logic                mismatch;
  logic [CNT_W-1:0]    cnt_next;
  logic [15:0]         sum16;

  assign mismatch = err_bit_i ^ ref_bit_i;
  assign sum16    = sat_add1(16'(cnt_q), mismatch, 16'(CNT_MAX));
  assign cnt_next = sum16[CNT_W-1:0];
  assign done_o   = en_i && !clr_i && (qidx_q == LAST_Q);
  assign count_o  = cnt_next;
  assign cnt_q_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      qidx_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      qidx_q <= '0;
    end else if (en_i) begin
      qidx_q <= qidx_q + 1'b1;
      if (qidx_q == LAST_Q) cnt_q <= '0;
      else                  cnt_q <= cnt_next;
    end
  end

endmodule

// File: rtl/sar_step_ctrl.sv
module sar_step_ctrl #(
  parameter int CTRL_W = 6,
  parameter int CNT_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              done_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CNT_W-1:0]  target_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CTRL_W-1:0] trial_o,
  output logic              locked_o
);
  import sar_cal_pkg::*;

  localparam logic [CTRL_W-1:0] MSB_ONLY = {1'b1, {(CTRL_W-1){1'b0}}};

  cal_state_e        state_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] mask_q;
  logic [CTRL_W-1:0] next_mask;
  logic [CTRL_W-1:0] kept_ctrl;
  logic              keep_bit;

  assign keep_bit  = (count_i >= target_i);
  assign next_mask = mask_q >> 1;
  assign kept_ctrl = keep_bit ? ctrl_q : (ctrl_q & ~mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CAL_BASE;
      ctrl_q  <= '0;
      mask_q  <= '0;
    end else if (clr_i) begin
      state_q <= CAL_BASE;
      ctrl_q  <= '0;
      mask_q  <= '0;
    end else if (done_i) begin
      unique case (state_q)
        CAL_BASE: begin
          ctrl_q  <= MSB_ONLY;
          mask_q  <= MSB_ONLY;
          state_q <= CAL_TRIAL;
        end
        CAL_TRIAL: begin
          ctrl_q <= kept_ctrl | next_mask;
          mask_q <= next_mask;
          if (mask_q[0]) state_q <= CAL_LOCK;
        end
        default: ;
      endcase
    end
  end

  assign ctrl_o   = ctrl_q;
  assign trial_o  = mask_q;
  assign locked_o = (state_q == CAL_LOCK);

endmodule

// File: rtl/sar_cal_ctrl.sv
module sar_cal_ctrl #(
  parameter int CTRL_W   = 6,
  parameter int WIN_LOG2 = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                recal_i,
  input  logic                query_i,
  input  logic                err_bit_i,
  input  logic                ref_bit_i,
  input  logic [WIN_LOG2-1:0] target_i,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic                locked_o
);

  logic                acc_en;
  logic                acc_done;
  logic [WIN_LOG2-1:0] acc_count;
  logic [WIN_LOG2-1:0] acc_cnt_q;
  logic [CTRL_W-1:0]   trial_mask;
  logic                locked;

  assign acc_en = query_i && !locked;

  err_window_acc #(.WIN_LOG2(WIN_LOG2)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (recal_i),
    .en_i     (acc_en),
    .err_bit_i(err_bit_i),
    .ref_bit_i(ref_bit_i),
    .done_o   (acc_done),
    .count_o  (acc_count),
    .cnt_q_o  (acc_cnt_q)
  );

  sar_step_ctrl #(.CTRL_W(CTRL_W), .CNT_W(WIN_LOG2)) u_step (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (recal_i),
    .done_i  (acc_done),
    .count_i (acc_count),
    .target_i(target_i),
    .ctrl_o  (ctrl_o),
    .trial_o (trial_mask),
    .locked_o(locked)
  );

  assign locked_o = locked;

endmodule

// File: rtl/sar_cal_ctrl_chk.sv
module sar_cal_ctrl_chk #(
  parameter int CTRL_W   = 6,
  parameter int WIN_LOG2 = 10
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                recal_i,
  input logic                query_i,
  input logic [CTRL_W-1:0]   ctrl_o,
  input logic                locked_o,
  input logic                acc_done,
  input logic [WIN_LOG2-1:0] acc_cnt_q,
  input logic [CTRL_W-1:0]   trial_mask
);
  localparam logic [WIN_LOG2-1:0] CNT_MAX = {WIN_LOG2{1'b1}};

  assert_recal_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recal_i |=> (ctrl_o == '0) && !locked_o);

  assert_idle_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!query_i && !recal_i) |=> $stable(ctrl_o) && $stable(locked_o));

  assert_lock_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !recal_i) |=> locked_o && $stable(ctrl_o));

  assert_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_cnt_q == CNT_MAX && query_i && !locked_o && !recal_i && !acc_done)
      |=> acc_cnt_q == CNT_MAX);

  assert_msb_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_o && ctrl_o == '0 && acc_done && !recal_i) |=> ctrl_o[CTRL_W-1]);

  assert_low_bits_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> ((ctrl_o & (trial_mask - 1'b1)) == '0));

endmodule

bind sar_cal_ctrl sar_cal_ctrl_chk #(.CTRL_W(CTRL_W), .WIN_LOG2(WIN_LOG2)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .recal_i   (recal_i),
  .query_i   (query_i),
  .ctrl_o    (ctrl_o),
  .locked_o  (locked_o),
  .acc_done  (acc_done),
  .acc_cnt_q (acc_cnt_q),
  .trial_mask(trial_mask)
);

// File: tb/sar_cal_ctrl_bench.sv
module sar_cal_ctrl_bench;
  localparam int CW  = 6;
  localparam int WL  = 3;
  localparam int WIN = 1 << WL;
  localparam int CMAX = WIN - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recal = 1'b0, query = 1'b0, err_b = 1'b0, ref_b = 1'b0;
  logic [WL-1:0] target = '0;
  logic [CW-1:0] ctrl;
  logic locked;

  int checks = 0, failures = 0, cycles = 0;
  bit done_flag = 0;

  int m_ctrl, m_locked, m_cnt, m_q, m_step;

  always #2 clk = ~clk;

  sar_cal_ctrl #(.CTRL_W(CW), .WIN_LOG2(WL)) u_sar_cal_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .recal_i(recal), .query_i(query),
    .err_bit_i(err_b), .ref_bit_i(ref_b), .target_i(target),
    .ctrl_o(ctrl), .locked_o(locked)
  );

  // Behavioural reference: window tally, then one binary-search decision
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || recal) begin
      m_ctrl = 0; m_locked = 0; m_cnt = 0; m_q = 0; m_step = 0;
    end else if (query && !m_locked) begin
      int c;
      c = m_cnt + ((err_b != ref_b) ? 1 : 0);
      if (c > CMAX) c = CMAX;
      if (m_q == WIN - 1) begin
        if (m_step == 0) begin
          m_ctrl = 1 << (CW - 1);
          m_step = 1;
        end else begin
          int b;
          b = CW - m_step;
          if (c < int'(target)) m_ctrl = m_ctrl & ~(1 << b);
          if (m_step == CW) m_locked = 1;
          else begin
            m_ctrl = m_ctrl | (1 << (b - 1));
            m_step = m_step + 1;
          end
        end
        m_cnt = 0; m_q = 0;
      end else begin
        m_cnt = c; m_q = m_q + 1;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done_flag) begin
      check("R2/R6 ctrl vs model", int'(ctrl), m_ctrl);
      check("R7/R8 locked vs model", int'(locked), m_locked);
    end
  end

  always @(posedge clk) begin
    if (cycles > 50000 && !done_flag) begin
      done_flag = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // One window: first n_err queries mismatched; optional idle mismatch cycles (R1)
  task automatic run_window(input int n_err, input bit gaps);
    for (int i = 0; i < WIN; i++) begin
      if (gaps) begin
        @(negedge clk); query = 0; err_b = 1; ref_b = 0;
      end
      @(negedge clk);
      query = 1;
      ref_b = i[0];
      err_b = i[0] ^ (i < n_err);
    end
    @(negedge clk); query = 0; err_b = 0; ref_b = 0;
  endtask

  task automatic do_recal();
    @(negedge clk); recal = 1; query = 0;
    @(negedge clk); recal = 0;
  endtask

  function automatic int plant_a(input int c);
    return 8 - c / 8;
  endfunction

  function automatic int plant_b(input int c);
    if (c < 20) return 8;
    if (c < 45) return 3;
    return 0;
  endfunction

  function automatic int expect_code(input int sel, input int tgt);
    int best = 0;
    for (int c = 0; c < (1 << CW); c++) begin
      int e;
      e = (sel == 0) ? plant_a(c) : plant_b(c);
      if (e > CMAX) e = CMAX;
      if (e >= tgt) best = c;
    end
    return best;
  endfunction

  task automatic calibrate(input int sel, input bit gaps);
    for (int w = 0; w < CW + 1 && !locked; w++) begin
      int n;
      n = (sel == 0) ? plant_a(int'(ctrl)) : plant_b(int'(ctrl));
      run_window(n, gaps);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R4 ctrl in reset", int'(ctrl), 0);
    check("R4 locked in reset", int'(locked), 0);
    rst_n = 1;
    @(negedge clk);
    check("R4 ctrl after reset", int'(ctrl), 0);

    // Plant A, target 4, idle mismatches between queries
    target = 3'd4;
    run_window(8, 1'b1);
    check("R5 msb after base window", int'(ctrl), 32);
    check("R1 idle mismatches ignored, still unlocked", int'(locked), 0);
    calibrate(0, 1'b1);
    check("R7 locked after search A", int'(locked), 1);
    check("R7 final code A", int'(ctrl), expect_code(0, 4));

    // Locked: queries full of errors ignored
    begin
      int held;
      held = int'(ctrl);
      run_window(0, 1'b0); run_window(8, 1'b0); run_window(3, 1'b0);
      check("R8 code held while locked", int'(ctrl), held);
      check("R8 lock held", int'(locked), 1);
    end

    // Recal in mid-window with a query in the same cycle
    do_recal();
    check("R9 ctrl cleared", int'(ctrl), 0);
    check("R9 lock cleared", int'(locked), 0);
    target = 3'd3;
    run_window(8, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); query = 1; err_b = 1; ref_b = 0;
    end
    @(negedge clk); recal = 1; query = 1; err_b = 1; ref_b = 0;
    @(negedge clk); recal = 0; query = 0;
    check("R9 recal over query ctrl", int'(ctrl), 0);
    calibrate(1, 1'b0);
    check("R9 R7 final code B after restart", int'(ctrl), expect_code(1, 3));
    check("R7 locked B", int'(locked), 1);

    // All errors, target at counter max: saturation keeps every bit
    do_recal();
    target = 3'd7;
    for (int w = 0; w < CW + 1; w++) run_window(8, 1'b0);
    check("R3 saturated count keeps all bits", int'(ctrl), 63);

    // Count equal to target keeps, one above clears all
    do_recal();
    target = 3'd5;
    for (int w = 0; w < CW + 1; w++) run_window(5, 1'b0);
    check("R10 equal count keeps bits", int'(ctrl), 63);
    do_recal();
    target = 3'd6;
    for (int w = 0; w < CW + 1; w++) run_window(5, 1'b0);
    check("R10 count below target clears bits", int'(ctrl), 0);
    check("R7 locked at zero code", int'(locked), 1);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule